// File: doc/BRIEF.md
# Processor Low-Power Mode Controller

This block is the state machine that moves a processor core between normal operation and three low-power modes of increasing depth: a light mode, a medium mode and a deep mode. Software asks for a mode with a one-cycle request. The controller then runs a short entry phase. An external interrupt in that phase cancels the request. After the entry phase the controller switches off the enables of the units that the chosen mode does not keep.

In the light mode only the core stops and the cache stays powered, so coherency is kept. In the medium mode the cache also turns off and only the clock generator keeps running. In the deep mode the clock generator is off as well. Each mode accepts its own set of wakeup sources. On a qualified wakeup the controller brings the units back in order and holds the core off for a resume time that grows with the depth of the mode. From the deep mode it first restarts the clock generator and waits for its lock signal, or for a timeout, before it brings back the cache. The clock and the clock generator are modelled only as enable outputs and a lock input.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While rst_ni is low (asynchronously) and after its release, mode_o is 0 and core_en_o, cache_en_o and pll_en_o are all 1.
- R2: In RUN, req_valid_i with req_mode_i equal to 1 (DOZE), 2 (NAP) or 3 (SLEEP) starts an entry phase of ENTRY_CYC cycles, during which all enables stay 1 and mode_o stays 0. After that mode_o reports the code (0=RUN, 1=DOZE, 2=NAP, 3=SLEEP). A request with code 0 has no effect.
- R3: A request made while not in RUN has no effect: mode_o keeps its value until wakeup, and the request is not taken up after the return to RUN.
- R4: ext_irq_i high during the entry phase, or in the same cycle as the request, cancels the entry: mode_o stays 0 and all enables stay 1.
- R5: In DOZE, core_en_o=0, cache_en_o=1 and pll_en_o=1.
- R6: In NAP, core_en_o=0, cache_en_o=0 and pll_en_o=1.
- R7: In SLEEP, core_en_o, cache_en_o and pll_en_o are all 0.
- R8: DOZE wakes on ext_irq_i or sw_wake_i. idle_expire_i has no effect in DOZE.
- R9: NAP wakes on ext_irq_i or idle_expire_i. sw_wake_i has no effect in NAP.
- R10: SLEEP wakes only on ext_irq_i. sw_wake_i and idle_expire_i have no effect.
- R11: After a wakeup from DOZE or NAP, sampled at clock edge W, the controller resumes with core_en_o=0, cache_en_o=1 and pll_en_o=1, and mode_o still shows the mode. RUN returns (all enables 1, mode_o=0) after edge W+DOZE_LAT or W+NAP_LAT respectively.
- R12: After a wakeup from SLEEP at edge W, only pll_en_o is 1. This lasts until pll_lock_i is sampled high, or for at most PLL_TMO cycles. The controller then holds cache_en_o=1 and pll_en_o=1 with the core off for SLEEP_LAT cycles, then returns to RUN. With lock first seen at edge W+k, RUN follows edge W+k+SLEEP_LAT. Without lock, RUN follows edge W+PLL_TMO+SLEEP_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 2 | Requested mode code, 1=DOZE, 2=NAP, 3=SLEEP |
| ext_irq_i | input | 1 | External interrupt |
| sw_wake_i | input | 1 | Software wake request |
| idle_expire_i | input | 1 | Idle timer expiry |
| pll_lock_i | input | 1 | Clock generator lock indication |
| core_en_o | output | 1 | Core units enable |
| cache_en_o | output | 1 | Cache enable |
| pll_en_o | output | 1 | Clock generator enable |
| mode_o | output | 2 | Current mode, 0=RUN, 1=DOZE, 2=NAP, 3=SLEEP |

## Verification
Each low-power mode is tried with one source it must ignore, followed by each source that must wake it. This shows that the wake qualification depends on the mode and does not accept any input at all. In the deep mode, wakeups with and without a lock indication show that the resume time follows the lock input and is not a fixed count. For each mode, the measured resume time from the wake edge to the core enable tells the three latencies apart. Further directed cases cover a code-0 request, a request made while asleep, an interrupt during entry, and a reset taken from the deep mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_DOZE  = 2'd1,
    MODE_NAP   = 2'd2,
    MODE_SLEEP = 2'd3
  } pmc_mode_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_ENTER,
    ST_LOW,
    ST_PLL_WAIT,
    ST_RESUME
  } pmc_state_e;

  localparam int unsigned NUM_UNITS  = 3;
  localparam int unsigned UNIT_CORE  = 0;
  localparam int unsigned UNIT_CACHE = 1;
  localparam int unsigned UNIT_PLL   = 2;

  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned SRC_IRQ  = 0;
  localparam int unsigned SRC_SW   = 1;
  localparam int unsigned SRC_IDLE = 2;

  // units kept alive while resting in a mode, bit index = UNIT_*
  function automatic logic [NUM_UNITS-1:0] keep_mask(pmc_mode_e m);
    logic [NUM_UNITS-1:0] k;
    k = '0;
    case (m)
      MODE_RUN:   k = '1;
      MODE_DOZE:  begin k[UNIT_CACHE] = 1'b1; k[UNIT_PLL] = 1'b1; end
      MODE_NAP:   k[UNIT_PLL] = 1'b1;
      default:    k = '0;
    endcase
    return k;
  endfunction

  // wake sources honoured per mode, bit index = SRC_*
  function automatic logic [NUM_SRC-1:0] wake_mask(pmc_mode_e m);
    logic [NUM_SRC-1:0] a;
    a = '0;
    case (m)
      MODE_DOZE:  begin a[SRC_IRQ] = 1'b1; a[SRC_SW] = 1'b1; end
      MODE_NAP:   begin a[SRC_IRQ] = 1'b1; a[SRC_IDLE] = 1'b1; end
      MODE_SLEEP: a[SRC_IRQ] = 1'b1;
      default:    a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual
  import pmc_pkg::*;
(
  input  logic                 armed_i,
  input  pmc_mode_e            mode_i,
  input  logic [NUM_SRC-1:0]   src_i,
  output logic                 wake_o
);

  logic [NUM_SRC-1:0] allow;
  logic [NUM_SRC-1:0] hit;

  assign allow = wake_mask(mode_i);

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_src
    assign hit[b] = src_i[b] & allow[b];
  end

  assign wake_o = armed_i & (|hit);

endmodule

// File: rtl/pmc_unit_en.sv
module pmc_unit_en
  import pmc_pkg::*;
(
  input  pmc_state_e           state_i,
  input  pmc_mode_e            mode_i,
  output logic [NUM_UNITS-1:0] en_o
);

  logic [NUM_UNITS-1:0] keep;

  assign keep = keep_mask(mode_i);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic en;
    always_comb begin
      case (state_i)
        ST_LOW:      en = keep[u];
        ST_PLL_WAIT: en = (u == UNIT_PLL);   // clock generator first
        ST_RESUME:   en = (u != UNIT_CORE);  // core last
        default:     en = 1'b1;
      endcase
    end
    assign en_o[u] = en;
  end

endmodule

// File: rtl/pmc_resume_cnt.sv
module pmc_resume_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned ENTRY_CYC = 3,
  parameter int unsigned DOZE_LAT  = 2,
  parameter int unsigned NAP_LAT   = 6,
  parameter int unsigned SLEEP_LAT = 10,
  parameter int unsigned PLL_TMO   = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_mode_i,
  input  logic       ext_irq_i,
  input  logic       sw_wake_i,
  input  logic       idle_expire_i,
  input  logic       pll_lock_i,
  output logic       core_en_o,
  output logic       cache_en_o,
  output logic       pll_en_o,
  output logic [1:0] mode_o
);

  localparam int unsigned MAX_A   = (ENTRY_CYC > DOZE_LAT) ? ENTRY_CYC : DOZE_LAT;
  localparam int unsigned MAX_B   = (NAP_LAT > SLEEP_LAT) ? NAP_LAT : SLEEP_LAT;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CNT = (MAX_C > PLL_TMO) ? MAX_C : PLL_TMO;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  localparam logic [CNT_W-1:0] LD_ENTRY = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] LD_DOZE  = CNT_W'(DOZE_LAT - 1);
  localparam logic [CNT_W-1:0] LD_NAP   = CNT_W'(NAP_LAT - 1);
  localparam logic [CNT_W-1:0] LD_SLEEP = CNT_W'(SLEEP_LAT - 1);
  localparam logic [CNT_W-1:0] LD_TMO   = CNT_W'(PLL_TMO - 1);

  pmc_state_e state_q, state_d;
  pmc_mode_e  tgt_q, tgt_d;
  pmc_mode_e  req_mode;

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  logic             wake;
  logic [NUM_SRC-1:0]   src;
  logic [NUM_UNITS-1:0] unit_en;

  assign req_mode = pmc_mode_e'(req_mode_i);

  always_comb begin
    src           = '0;
    src[SRC_IRQ]  = ext_irq_i;
    src[SRC_SW]   = sw_wake_i;
    src[SRC_IDLE] = idle_expire_i;
  end

  pmc_wake_qual i_wake_qual (
    .armed_i (state_q == ST_LOW),
    .mode_i  (tgt_q),
    .src_i   (src),
    .wake_o  (wake)
  );

  pmc_resume_cnt #(.CNT_W(CNT_W)) i_resume_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .zero_o (cnt_zero)
  );

  always_comb begin
    state_d  = state_q;
    tgt_d    = tgt_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_RUN: begin
        // an interrupt alongside the request also blocks entry
        if (req_valid_i && req_mode != MODE_RUN && !ext_irq_i) begin
          state_d  = ST_ENTER;
          tgt_d    = req_mode;
          cnt_load = 1'b1;
          cnt_val  = LD_ENTRY;
        end
      end
      ST_ENTER: begin
        if (ext_irq_i)     state_d = ST_RUN;
        else if (cnt_zero) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (wake) begin
          cnt_load = 1'b1;
          if (tgt_q == MODE_SLEEP) begin
            state_d = ST_PLL_WAIT;
            cnt_val = LD_TMO;
          end else begin
            state_d = ST_RESUME;
            cnt_val = (tgt_q == MODE_NAP) ? LD_NAP : LD_DOZE;
          end
        end
      end
      ST_PLL_WAIT: begin
        if (pll_lock_i || cnt_zero) begin
          state_d  = ST_RESUME;
          cnt_load = 1'b1;
          cnt_val  = LD_SLEEP;
        end
      end
      ST_RESUME: begin
        if (cnt_zero) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      tgt_q   <= MODE_RUN;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
    end
  end

  pmc_unit_en i_unit_en (
    .state_i (state_q),
    .mode_i  (tgt_q),
    .en_o    (unit_en)
  );

  assign core_en_o  = unit_en[UNIT_CORE];
  assign cache_en_o = unit_en[UNIT_CACHE];
  assign pll_en_o   = unit_en[UNIT_PLL];
  assign mode_o     = (state_q == ST_RUN || state_q == ST_ENTER) ? MODE_RUN : tgt_q;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_irq_i,
  input logic       sw_wake_i,
  input logic       idle_expire_i,
  input logic       pll_lock_i,
  input logic       core_en_o,
  input logic       cache_en_o,
  input logic       pll_en_o,
  input logic [1:0] mode_o
);

  p_core_off_in_mode_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |-> !core_en_o);

  p_mode_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0) |=> (mode_o == $past(mode_o) || mode_o == 2'd0));

  p_irq_blocks_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd0 && ext_irq_i) |=> (mode_o == 2'd0));

  p_cache_needs_pll_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cache_en_o |-> pll_en_o);

  p_lock_releases_cache_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && pll_en_o && !cache_en_o && pll_lock_i) |=> cache_en_o);

  p_sleep_irq_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && !pll_en_o && !ext_irq_i) |=> (!pll_en_o && mode_o == 2'd3));

  p_nap_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !cache_en_o && !ext_irq_i && !idle_expire_i)
      |=> (mode_o == 2'd2 && !cache_en_o));

  p_doze_cache_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1) |-> (cache_en_o && pll_en_o));

  // sw_wake_i only matters through DOZE; kept for a complete port view
  logic unused_sw;
  assign unused_sw = sw_wake_i;

endmodule

bind pwr_sleep_ctrl pmc_checker i_pmc_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_irq_i     (ext_irq_i),
  .sw_wake_i     (sw_wake_i),
  .idle_expire_i (idle_expire_i),
  .pll_lock_i    (pll_lock_i),
  .core_en_o     (core_en_o),
  .cache_en_o    (cache_en_o),
  .pll_en_o      (pll_en_o),
  .mode_o        (mode_o)
);

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

  localparam int ENTRY = 3;
  localparam int DLAT  = 2;
  localparam int NLAT  = 6;
  localparam int SLAT  = 10;
  localparam int TMO   = 20;
  localparam int LOCK_DLY = 4; // bench lock model: lock seen at edge W+4

  // src bits: {idle, sw, irq}
  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] bad;
    logic [2:0] good;
    logic       lock;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 3'b100, 3'b001, 1'b0},
    '{2'd1, 3'b100, 3'b010, 1'b0},
    '{2'd2, 3'b010, 3'b001, 1'b0},
    '{2'd2, 3'b010, 3'b100, 1'b0},
    '{2'd3, 3'b110, 3'b001, 1'b0},
    '{2'd3, 3'b110, 3'b001, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic irq = 1'b0, sw = 1'b0, idle = 1'b0;
  logic lock_en = 1'b0;
  logic [2:0] lock_sh = 3'b000;
  logic pll_lock;
  logic core_en, cache_en, pll_en;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) lock_sh <= {lock_sh[1:0], pll_en};
  assign pll_lock = lock_en & (&lock_sh);

  pwr_sleep_ctrl #(
    .ENTRY_CYC(ENTRY), .DOZE_LAT(DLAT), .NAP_LAT(NLAT),
    .SLEEP_LAT(SLAT), .PLL_TMO(TMO)
  ) i_pwr_sleep_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .ext_irq_i(irq), .sw_wake_i(sw), .idle_expire_i(idle), .pll_lock_i(pll_lock),
    .core_en_o(core_en), .cache_en_o(cache_en), .pll_en_o(pll_en), .mode_o(mode)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // {pll, cache, core} while resting in a mode (R5, R6, R7)
  function automatic logic [2:0] low_en(logic [1:0] m);
    case (m)
      2'd1:    return 3'b110;
      2'd2:    return 3'b100;
      2'd3:    return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic int exp_lat(logic [1:0] m, logic lk);
    case (m)
      2'd1:    return DLAT;
      2'd2:    return NLAT;
      default: return lk ? (LOCK_DLY + SLAT) : (TMO + SLAT);
    endcase
  endfunction

  function automatic logic [2:0] ens();
    return {pll_en, cache_en, core_en};
  endfunction

  task automatic request(logic [1:0] m);
    req_valid = 1'b1; req_mode = m;
    cycles(1);
    req_valid = 1'b0; req_mode = 2'd0;
  endtask

  task automatic enter(logic [1:0] m);
    request(m);
    cycles(ENTRY - 1);
    chk("R2 entry mode", 32'(mode), 32'd0);
    chk("R2 entry enables", 32'(ens()), 32'h7);
    cycles(1);
    chk("R2 mode code", 32'(mode), 32'(m));
  endtask

  task automatic pulse(logic [2:0] s);
    {idle, sw, irq} = s;
    cycles(1);
    {idle, sw, irq} = 3'b000;
  endtask

  task automatic wait_run(output int n);
    n = 0;
    while (!core_en && n < 200) begin
      cycles(1);
      n++;
    end
  endtask

  initial begin
    int lat;
    cycles(2);
    chk("R1 enables in reset", 32'(ens()), 32'h7);
    chk("R1 mode in reset", 32'(mode), 32'd0);
    rst_ni = 1'b1;
    cycles(2);
    chk("R1 enables after reset", 32'(ens()), 32'h7);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      lock_en = v.lock;
      enter(v.mode);
      chk($sformatf("R5/R6/R7 low enables mode %0d", v.mode), 32'(ens()), 32'(low_en(v.mode)));
      pulse(v.bad);
      cycles(2);
      chk($sformatf("R8/R9/R10 ignored src %b mode", v.bad), 32'(mode), 32'(v.mode));
      chk($sformatf("R8/R9/R10 ignored src %b enables", v.bad), 32'(ens()), 32'(low_en(v.mode)));
      pulse(v.good);
      if (v.mode == 2'd3)
        chk("R12 pll first", 32'(ens()), 32'h4);
      else
        chk("R11 resume enables", 32'(ens()), 32'h6);
      chk("R11 mode during resume", 32'(mode), 32'(v.mode));
      wait_run(lat);
      chk($sformatf("R11/R12 latency mode %0d lock %0d", v.mode, v.lock), 32'(lat),
          32'(exp_lat(v.mode, v.lock)));
      chk("R11 back in RUN enables", 32'(ens()), 32'h7);
      chk("R11 back in RUN mode", 32'(mode), 32'd0);
      lock_en = 1'b0;
      cycles(2);
    end

    // R12: cache comes back before RUN once lock is seen
    lock_en = 1'b1;
    enter(2'd3);
    cycles(3);
    pulse(3'b001);
    cycles(LOCK_DLY);
    chk("R12 cache after lock", 32'(ens()), 32'h6);
    wait_run(lat);
    chk("R12 remaining resume", 32'(lat), 32'(SLAT));
    lock_en = 1'b0;
    cycles(2);

    // R2: code 0 request is no request
    request(2'd0);
    cycles(ENTRY + 2);
    chk("R2 code 0 ignored", 32'(mode), 32'd0);
    chk("R2 code 0 enables", 32'(ens()), 32'h7);

    // R3: request while in DOZE
    enter(2'd1);
    request(2'd3);
    cycles(ENTRY + 2);
    chk("R3 mode kept", 32'(mode), 32'd1);
    chk("R3 enables kept", 32'(ens()), 32'h6);
    pulse(3'b010);
    wait_run(lat);
    chk("R3 wake latency", 32'(lat), 32'(DLAT));
    cycles(ENTRY + 2);
    chk("R3 request not replayed", 32'(mode), 32'd0);

    // R4: interrupt during entry
    request(2'd2);
    pulse(3'b001);
    for (int k = 0; k < ENTRY + 3; k++) begin
      chk("R4 abort mode", 32'(mode), 32'd0);
      cycles(1);
    end
    chk("R4 abort enables", 32'(ens()), 32'h7);

    // R4: interrupt together with request
    irq = 1'b1;
    request(2'd1);
    irq = 1'b0;
    cycles(ENTRY + 2);
    chk("R4 same-cycle abort", 32'(mode), 32'd0);

    // R1: asynchronous reset from SLEEP
    enter(2'd3);
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async reset enables", 32'(ens()), 32'h7);
    chk("R1 async reset mode", 32'(mode), 32'd0);
    cycles(2);
    rst_ni = 1'b1;
    cycles(2);
    chk("R1 run after reset", 32'(ens()), 32'h7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule